// File: doc/BRIEF.md
# Gated and Interpolated Sample Rate Controller

This block sets the rate at which downstream signal processing sees input samples. It takes a pair of 10-bit in-phase and quadrature words and an active-low enable. It passes them through a two-stage registered pipeline. A processing strobe travels beside the data so that later stages know which output cycles carry a new sample.

Bit 1 of a control byte selects one of two modes. Gated mode serves input streams that run slower than the clock. A sample is taken only on cycles where the enable is sampled low, and the strobe marks each of those samples exactly once. Interpolated mode raises the effective time resolution. The strobe is high on every cycle. A cycle with the enable low carries the input sample, and a cycle with the enable high carries zero in its place.

Top module: `sample_rate_gate`

## Requirements
- R1: Bit 1 of `fmt_ctrl` selects the mode: 0 is gated mode and 1 is interpolated mode. All other bits of `fmt_ctrl` have no effect on the outputs.
- R2: In gated mode, when `smp_en_n` is sampled low at clock edge k, the I and Q words sampled at edge k appear on `i_out` and `q_out` after edge k+1. At the same time `proc_en` is 1.
- R3: In gated mode, when `smp_en_n` is sampled high at edge k, `proc_en` is 0 after edge k+1. The data inputs are ignored, and `i_out` and `q_out` keep their previous values.
- R4: In gated mode, the number of cycles with `proc_en` high equals the number of edges at which `smp_en_n` was sampled low.
- R5: In interpolated mode, `proc_en` is 1 two edges after every edge, whatever the level of `smp_en_n`.
- R6: In interpolated mode, an edge with `smp_en_n` low delivers the input sample two edges later. An edge with `smp_en_n` high delivers 0 on both `i_out` and `q_out` two edges later.
- R7: A synchronous active-high `rst` clears `i_out`, `q_out` and `proc_en` to 0.
- R8: Data words pass through bit for bit over the full 10-bit range, including 10'h000 and 10'h3FF, and I and Q are never swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_ctrl | input | 8 | Formatting control byte; bit 1 selects the mode |
| smp_en_n | input | 1 | Sample enable, active low |
| i_in | input | 10 | In-phase input word |
| q_in | input | 10 | Quadrature input word |
| i_out | output | 10 | Registered in-phase output |
| q_out | output | 10 | Registered quadrature output |
| proc_en | output | 1 | Processing strobe aligned with the output data |

## Verification
In gated mode the bench drives an enable that alternates, then one held low for a run, then sparse single-cycle pulses. These patterns separate a strobe that is too late or too early, or doubled, from one that is correctly aligned, and they show whether data leaks through on disabled cycles. In interpolated mode the bench mixes enable high and enable low. This separates zero insertion from holding or passing the input. A control byte with every bit set except bit 1 checks that only bit 1 decides the mode. Extreme and distinct I/Q codes reveal truncation or swapped lanes.

// File: rtl/sample_rate_gate.sv
module sample_rate_gate #(
  parameter int DATA_W   = 10,
  parameter int CTRL_W   = 8,
  parameter int MODE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] fmt_ctrl,
  input  logic              smp_en_n,
  input  logic [DATA_W-1:0] i_in,
  input  logic [DATA_W-1:0] q_in,
  output logic [DATA_W-1:0] i_out,
  output logic [DATA_W-1:0] q_out,
  output logic              proc_en
);

  logic              interp;
  logic              take;
  logic [DATA_W-1:0] i_s1, q_s1;
  logic              v_s1;

  assign interp = fmt_ctrl[MODE_BIT];
  assign take   = interp | ~smp_en_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_s1 <= '0;
      q_s1 <= '0;
      v_s1 <= 1'b0;
    end else begin
      v_s1 <= take;
      if (take) begin
        i_s1 <= smp_en_n ? '0 : i_in;
        q_s1 <= smp_en_n ? '0 : q_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_out   <= '0;
      q_out   <= '0;
      proc_en <= 1'b0;
    end else begin
      proc_en <= v_s1;
      if (v_s1) begin
        i_out <= i_s1;
        q_out <= q_s1;
      end
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2 R5
  strobe_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (proc_en == ($past(fmt_ctrl[MODE_BIT], 2) || !$past(smp_en_n, 2))));

  // R2
  gated_data_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && !$past(fmt_ctrl[MODE_BIT], 2) && !$past(smp_en_n, 2))
      |-> (i_out == $past(i_in, 2) && q_out == $past(q_in, 2)));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !proc_en) |-> ($stable(i_out) && $stable(q_out)));

  // R6
  zero_stuff_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(fmt_ctrl[MODE_BIT], 2) && $past(smp_en_n, 2))
      |-> (i_out == '0 && q_out == '0));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (i_out == '0 && q_out == '0 && !proc_en));

endmodule

// File: tb/tb_sample_rate_gate.sv
module tb_sample_rate_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] fmt_ctrl = 8'h00;
  logic       smp_en_n = 1'b1;
  logic [9:0] i_in = '0, q_in = '0;
  logic [9:0] i_out, q_out;
  logic       proc_en;

  int compared = 0;
  int mismatched = 0;

  sample_rate_gate dut (
    .clk(clk), .rst(rst), .fmt_ctrl(fmt_ctrl), .smp_en_n(smp_en_n),
    .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out), .proc_en(proc_en)
  );

  always #2 clk = ~clk;

  // history of drives: index 1 = previous step, 2 = two steps back
  logic       h1_v, h2_v, h1_m, h2_m, h1_e, h2_e;
  logic [9:0] h1_i, h2_i, h1_q, h2_q;
  logic [9:0] exp_i, exp_q;
  int         strobe_seen;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic clear_hist();
    h1_v = 0; h2_v = 0; exp_i = '0; exp_q = '0;
  endtask

  task automatic step(input logic [7:0] ctrl, input logic en_n,
                      input logic [9:0] di, input logic [9:0] dq, input string tag);
    logic exp_pe;
    @(negedge clk);
    exp_pe = h2_v && (h2_m || !h2_e);
    if (exp_pe) begin
      exp_i = (h2_m && h2_e) ? 10'h000 : h2_i;
      exp_q = (h2_m && h2_e) ? 10'h000 : h2_q;
    end
    chk(tag, "proc_en", proc_en, exp_pe);
    chk(tag, "i_out", i_out, exp_i);
    chk(tag, "q_out", q_out, exp_q);
    if (proc_en) strobe_seen++;
    h2_v = h1_v; h2_m = h1_m; h2_e = h1_e; h2_i = h1_i; h2_q = h1_q;
    h1_v = 1'b1; h1_m = ctrl[1]; h1_e = en_n; h1_i = di; h1_q = dq;
    fmt_ctrl = ctrl; smp_en_n = en_n; i_in = di; q_in = dq;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_en_n = 1'b0; fmt_ctrl = 8'h02; i_in = 10'h155; q_in = 10'h2AA;
    repeat (3) @(negedge clk);
    chk("R7", "proc_en", proc_en, 0);
    chk("R7", "i_out", i_out, 0);
    chk("R7", "q_out", q_out, 0);
    rst = 1'b0; smp_en_n = 1'b1; fmt_ctrl = 8'h00; i_in = '0; q_in = '0;
    clear_hist();
  endtask

  task automatic test_gated_alternate();
    for (int k = 0; k < 12; k++)
      step(8'h00, k[0], 10'(k * 37 + 5), 10'(k * 91 + 3), "R2/R3");
    repeat (2) step(8'h00, 1'b1, 10'h3FF, 10'h3FF, "R3");
  endtask

  task automatic test_gated_count();
    int lows = 0;
    do_reset();
    strobe_seen = 0;
    for (int k = 0; k < 20; k++) begin
      logic en;
      en = (k % 5 == 0) ? 1'b0 : ((k >= 8 && k < 13) ? 1'b0 : 1'b1);
      if (!en) lows++;
      step(8'h00, en, 10'(k * 13), 10'(1023 - k * 7), "R4");
    end
    repeat (3) step(8'h00, 1'b1, 10'h111, 10'h222, "R3");
    chk("R4", "strobe count", strobe_seen, lows);
  endtask

  task automatic test_mode_bit_only();
    do_reset();
    for (int k = 0; k < 8; k++)
      step(8'hFD, (k % 3 != 0), 10'(k * 29 + 1), 10'(k * 53 + 2), "R1");
    for (int k = 0; k < 6; k++)
      step(8'h02, (k % 2 == 0), 10'(k * 41 + 9), 10'(k * 17 + 4), "R1");
  endtask

  task automatic test_interp();
    do_reset();
    for (int k = 0; k < 12; k++)
      step(8'h02, (k % 4 != 1), 10'(k * 77 + 6), 10'(k * 19 + 8), "R5/R6");
    repeat (2) step(8'h02, 1'b1, 10'h3AB, 10'h0CD, "R6");
  endtask

  task automatic test_extremes();
    do_reset();
    step(8'h00, 1'b0, 10'h3FF, 10'h000, "R8");
    step(8'h00, 1'b0, 10'h000, 10'h3FF, "R8");
    step(8'h00, 1'b0, 10'h2AA, 10'h155, "R8");
    step(8'h02, 1'b0, 10'h3FF, 10'h001, "R8");
    repeat (3) step(8'h00, 1'b1, 10'h000, 10'h000, "R8");
  endtask

  task automatic test_midstream_reset();
    step(8'h00, 1'b0, 10'h123, 10'h321, "R2");
    do_reset();
    step(8'h00, 1'b1, 10'h0F0, 10'h00F, "R7");
    step(8'h00, 1'b1, 10'h0F0, 10'h00F, "R7");
  endtask

  initial begin
    fork
      begin
        do_reset();
        test_gated_alternate();
        test_gated_count();
        test_mode_bit_only();
        test_interp();
        test_extremes();
        test_midstream_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule